// File: doc/BRIEF.md
# Flash Command Decoder and Status Register

This block sits between a synchronous host write port and the operation engines of a NOR-style flash controller. Each write carries a command byte in its low eight bits. Some commands take one bus cycle and pick what the read path returns: array data, the status word, identifier codes or query data. Others take two cycles: a setup byte, then a confirm byte or a data word. A finished two-cycle sequence fires a one-cycle strobe towards the matching engine, together with the address and data of the second cycle.

The block keeps an 8-bit status byte. In status mode it is returned twice, once in each byte lane of the 16-bit read word. The byte tracks three things: whether an engine is busy, which operation is suspended, and the sticky error flags reported by the engines on their done pulse. The block also decides whether a suspend or resume request is legal. It refuses a setup that would start a second operation while another one is running or suspended, except for a word program started during a suspended block erase.

Top module: `flash_cmd_ui`

## Requirements
- R1: After reset the read word equals `array_data`, every strobe is low, and the status word reads 8080h (bit 7 ready = 1, all other bits 0).
- R2: The single-cycle byte FFh selects array data, 70h the status word, 90h identifier data and 98h `query_data`, from the clock edge that takes the write. The status word carries the status byte in both bit 15..8 and bit 7..0. Within the byte, bit 0 always reads 0.
- R3: In identifier mode the read word is a function of `id_addr`: 0000h gives 00B0h and 0001h gives 0011h. Any other address whose offset inside a 2^15-word block equals 2 gives `{14'b0, lock_cfg}`. Every other address gives 0000h.
- R4: Each of these pairs fires a strobe for exactly one cycle, starting at the edge that takes the second write: 20h then D0h (block erase), 30h then D0h (chip erase), 40h or 10h then a data word (word program), C0h then a data word (OTP program). In that same cycle `op_addr`/`op_data` hold the second write, status bit 7 is 0 and the read mode is status.
- R5: 60h followed by 01h, D0h or 2Fh fires the lock-set, lock-clear or lock-down strobe for one cycle, and status bit 7 stays 1.
- R6: A second cycle other than D0h after 20h or 30h, or other than 01h/D0h/2Fh after 60h, fires no strobe and sets status bits 5 and 4 together.
- R7: `eng_done` sets status bit 7 to 1. It ORs `eng_flags[3]` into bit 5 (erase error), `eng_flags[2]` into bit 4 (program error), `eng_flags[1]` into bit 3 (protect-voltage abort) and `eng_flags[0]` into bit 1 (locked-block abort).
- R8: Status bits 5, 4, 3 and 1 stay set through any other command until 50h, which clears them and leaves bits 7, 6 and 2 unchanged.
- R9: A first-cycle byte that is not one of FFh, 70h, 50h, 90h, 98h, 20h, 30h, 40h, 10h, 60h or C0h leaves the read mode and the status unchanged and fires no strobe. This includes B0h and D0h when there is nothing to suspend or resume.
- R10: B0h while a block erase or word program is busy pulses `go_suspend`, sets bit 7 and sets bit 6 (erase) or bit 2 (program). B0h during a chip erase or OTP program is ignored and bit 7 stays 0.
- R11: D0h as a first cycle while ready, with an operation suspended, pulses `go_resume`, clears bit 7 and resumes the suspended program before the suspended erase, clearing bit 2 or bit 6 respectively.
- R12: While busy, every setup byte is ignored. While any operation is suspended, 20h, 30h and C0h are ignored, and 40h/10h are ignored only while a program is suspended. A word program started during a suspended erase is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| wr_addr | input | 23 | Address of the host write |
| wr_data | input | 16 | Data of the host write; bits 7..0 are the command byte |
| id_addr | input | 16 | Low address bits of the current read, used in identifier mode |
| array_data | input | 16 | Word from the array path |
| query_data | input | 16 | Word from the query table |
| lock_cfg | input | 2 | Lock configuration of the addressed block |
| rd_data | output | 16 | Read word selected by the read mode |
| go_blk_erase | output | 1 | Block erase launch strobe |
| go_chip_erase | output | 1 | Chip erase launch strobe |
| go_word_prog | output | 1 | Word program launch strobe |
| go_otp_prog | output | 1 | OTP program launch strobe |
| go_lock_set | output | 1 | Set-lock strobe |
| go_lock_clear | output | 1 | Clear-lock strobe |
| go_lock_down | output | 1 | Lock-down strobe |
| go_suspend | output | 1 | Suspend request strobe |
| go_resume | output | 1 | Resume request strobe |
| op_addr | output | 23 | Address latched from the launching write |
| op_data | output | 16 | Data latched from the launching write |
| eng_done | input | 1 | One-cycle completion pulse from the running engine |
| eng_flags | input | 4 | Error flags sampled with `eng_done` |

## Verification
The assertions assume that `eng_done` pulses only while an engine is busy, never in the same cycle as a host write, and never while the only pending work is suspended. The bench honours this: it raises `eng_done` for one cycle only after a launch or resume whose strobe it has already seen. It never overlaps `eng_done` with `wr_en`. The suspend, resume and refusal checks all run inside such bracketed busy windows.

// File: rtl/fcu_pkg.sv
// Shared command codes, read modes and event bundle for the flash command block.
// Assumes 8-bit command bytes carried in the low byte of the write data.
package fcu_pkg;

    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STAT  = 8'h50;
    localparam logic [7:0] CMD_READ_IDENT  = 8'h90;
    localparam logic [7:0] CMD_READ_QUERY  = 8'h98;
    localparam logic [7:0] CMD_SUSPEND     = 8'hB0;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_BLK_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CHIP_ERASE  = 8'h30;
    localparam logic [7:0] CMD_PROG_A      = 8'h40;
    localparam logic [7:0] CMD_PROG_B      = 8'h10;
    localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
    localparam logic [7:0] CMD_OTP_PROG    = 8'hC0;
    localparam logic [7:0] LCK_SET         = 8'h01;
    localparam logic [7:0] LCK_DOWN        = 8'h2F;

    // Strobe vector positions
    localparam int NGO       = 9;
    localparam int G_BERASE  = 0;
    localparam int G_CERASE  = 1;
    localparam int G_PROG    = 2;
    localparam int G_OTP     = 3;
    localparam int G_LKSET   = 4;
    localparam int G_LKCLR   = 5;
    localparam int G_LKDOWN  = 6;
    localparam int G_SUSP    = 7;
    localparam int G_RESUME  = 8;

    typedef enum logic [1:0] {
        RD_ARRAY, RD_STATUS, RD_IDENT, RD_QUERY
    } rd_mode_e;

    typedef enum logic [2:0] {
        SU_NONE, SU_BERASE, SU_CERASE, SU_PROG, SU_OTP, SU_LOCK
    } setup_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_BERASE, OP_CERASE, OP_PROG, OP_OTP
    } op_e;

    // Next-cycle status events produced by the decoder
    typedef struct packed {
        logic launch;
        logic susp_e;
        logic susp_p;
        logic res_e;
        logic res_p;
        logic bad_seq;
        logic clr_err;
    } sr_ev_t;

endpackage

// File: rtl/fcu_decoder.sv
// Command decoder: matches one- and two-cycle command sequences, tracks the
// running operation and decides suspend/resume legality. Strobes, read mode
// and latched operands are registered. Status events are combinational so
// that the status register changes at the same edge as the strobes.
// Assumes eng_done is only pulsed while an operation is running.
module fcu_decoder
    import fcu_pkg::*;
#(
    parameter int AW = 23,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic              sr_ready,
    input  logic              sr_susp_e,
    input  logic              sr_susp_p,
    input  logic              eng_done,
    output rd_mode_e          rd_mode,
    output sr_ev_t            ev,
    output logic [NGO-1:0]    go,
    output logic [AW-1:0]     op_addr,
    output logic [DW-1:0]     op_data
);

    setup_e         setup_q, setup_n;
    op_e            act_q, act_n;
    rd_mode_e       mode_q, mode_n;
    logic [NGO-1:0] go_n;
    logic           ld_op;
    logic [7:0]     cmd;
    logic           any_susp;

    assign cmd      = wr_data[7:0];
    assign any_susp = sr_susp_e | sr_susp_p;

    // Next-state decode of the write port
    always_comb begin
        setup_n = setup_q;
        act_n   = act_q;
        mode_n  = mode_q;
        go_n    = '0;
        ev      = '0;
        ld_op   = 1'b0;
        if (eng_done) act_n = OP_NONE;
        if (wr_en) begin
            if (setup_q != SU_NONE) begin
                setup_n = SU_NONE;
                mode_n  = RD_STATUS;
                case (setup_q)
                    SU_BERASE: begin
                        if (cmd == CMD_CONFIRM) begin
                            go_n[G_BERASE] = 1'b1; ev.launch = 1'b1;
                            act_n = OP_BERASE; ld_op = 1'b1;
                        end else ev.bad_seq = 1'b1;
                    end
                    SU_CERASE: begin
                        if (cmd == CMD_CONFIRM) begin
                            go_n[G_CERASE] = 1'b1; ev.launch = 1'b1;
                            act_n = OP_CERASE; ld_op = 1'b1;
                        end else ev.bad_seq = 1'b1;
                    end
                    SU_PROG: begin
                        go_n[G_PROG] = 1'b1; ev.launch = 1'b1;
                        act_n = OP_PROG; ld_op = 1'b1;
                    end
                    SU_OTP: begin
                        go_n[G_OTP] = 1'b1; ev.launch = 1'b1;
                        act_n = OP_OTP; ld_op = 1'b1;
                    end
                    SU_LOCK: begin
                        case (cmd)
                            LCK_SET:     begin go_n[G_LKSET]  = 1'b1; ld_op = 1'b1; end
                            CMD_CONFIRM: begin go_n[G_LKCLR]  = 1'b1; ld_op = 1'b1; end
                            LCK_DOWN:    begin go_n[G_LKDOWN] = 1'b1; ld_op = 1'b1; end
                            default:     ev.bad_seq = 1'b1;
                        endcase
                    end
                    default: ;
                endcase
            end else begin
                case (cmd)
                    CMD_READ_ARRAY:  mode_n = RD_ARRAY;
                    CMD_READ_STATUS: mode_n = RD_STATUS;
                    CMD_READ_IDENT:  mode_n = RD_IDENT;
                    CMD_READ_QUERY:  mode_n = RD_QUERY;
                    CMD_CLEAR_STAT:  ev.clr_err = 1'b1;
                    CMD_SUSPEND: begin
                        if (!sr_ready && act_q == OP_BERASE) begin
                            go_n[G_SUSP] = 1'b1; ev.susp_e = 1'b1;
                            act_n = OP_NONE; mode_n = RD_STATUS;
                        end else if (!sr_ready && act_q == OP_PROG) begin
                            go_n[G_SUSP] = 1'b1; ev.susp_p = 1'b1;
                            act_n = OP_NONE; mode_n = RD_STATUS;
                        end
                    end
                    CMD_CONFIRM: begin
                        if (sr_ready && sr_susp_p) begin
                            go_n[G_RESUME] = 1'b1; ev.res_p = 1'b1;
                            act_n = OP_PROG; mode_n = RD_STATUS;
                        end else if (sr_ready && sr_susp_e) begin
                            go_n[G_RESUME] = 1'b1; ev.res_e = 1'b1;
                            act_n = OP_BERASE; mode_n = RD_STATUS;
                        end
                    end
                    CMD_BLK_ERASE: if (sr_ready && !any_susp) begin
                        setup_n = SU_BERASE; mode_n = RD_STATUS;
                    end
                    CMD_CHIP_ERASE: if (sr_ready && !any_susp) begin
                        setup_n = SU_CERASE; mode_n = RD_STATUS;
                    end
                    CMD_PROG_A, CMD_PROG_B: if (sr_ready && !sr_susp_p) begin
                        setup_n = SU_PROG; mode_n = RD_STATUS;
                    end
                    CMD_OTP_PROG: if (sr_ready && !any_susp) begin
                        setup_n = SU_OTP; mode_n = RD_STATUS;
                    end
                    CMD_LOCK_SETUP: if (sr_ready) begin
                        setup_n = SU_LOCK; mode_n = RD_STATUS;
                    end
                    default: ;
                endcase
            end
        end
    end

    // State, strobe and operand registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q <= SU_NONE;
            act_q   <= OP_NONE;
            mode_q  <= RD_ARRAY;
            go      <= '0;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            setup_q <= setup_n;
            act_q   <= act_n;
            mode_q  <= mode_n;
            go      <= go_n;
            if (ld_op) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end

    assign rd_mode = mode_q;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go)); // R4
    AST_BAD_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
        ev.bad_seq |=> (go == '0)); // R6
    AST_OTP_NOT_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
        go[G_OTP] |-> (!sr_susp_e && !sr_susp_p)); // R12

endmodule

// File: rtl/fcu_status.sv
// Status byte: ready flag, two suspend flags and four sticky error flags.
// Updates on decoder events and on the engine done pulse; bit 0 is reserved.
// Assumes at most one decoder event per cycle.
module fcu_status
    import fcu_pkg::*;
#(
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sr_ev_t           ev,
    input  logic             eng_done,
    input  logic [NFLAG-1:0] eng_flags,
    output logic [7:0]       sr
);

    logic rdy, s_erase, s_prog, e_erase, e_prog, e_vpp, e_lock;

    // Status flag register; later statements take precedence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy     <= 1'b1;
            s_erase <= 1'b0;
            s_prog  <= 1'b0;
            e_erase <= 1'b0;
            e_prog  <= 1'b0;
            e_vpp   <= 1'b0;
            e_lock  <= 1'b0;
        end else begin
            if (eng_done) begin
                rdy     <= 1'b1;
                e_erase <= e_erase | eng_flags[3];
                e_prog  <= e_prog  | eng_flags[2];
                e_vpp   <= e_vpp   | eng_flags[1];
                e_lock  <= e_lock  | eng_flags[0];
            end
            if (ev.launch) rdy <= 1'b0;
            if (ev.susp_e) begin s_erase <= 1'b1; rdy <= 1'b1; end
            if (ev.susp_p) begin s_prog  <= 1'b1; rdy <= 1'b1; end
            if (ev.res_e)  begin s_erase <= 1'b0; rdy <= 1'b0; end
            if (ev.res_p)  begin s_prog  <= 1'b0; rdy <= 1'b0; end
            if (ev.bad_seq) begin
                e_erase <= 1'b1;
                e_prog  <= 1'b1;
            end
            if (ev.clr_err) begin
                e_erase <= 1'b0;
                e_prog  <= 1'b0;
                e_vpp   <= 1'b0;
                e_lock  <= 1'b0;
            end
        end
    end

    assign sr = {rdy, s_erase, e_erase, e_prog, e_vpp, s_prog, e_lock, 1'b0};

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sr[5] && !ev.clr_err) |=> sr[5]); // R8
    AST_BAD_SETS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        ev.bad_seq |=> (sr[5] && sr[4])); // R6

endmodule

// File: rtl/fcu_rdmux.sv
// Read word selection by read mode, including identifier decode.
// Assumes id_addr carries the low address bits of the current read.
module fcu_rdmux
    import fcu_pkg::*;
#(
    parameter int          DW       = 16,
    parameter int          OFS_W    = 16,
    parameter int          BLK_W    = 15,
    parameter logic [15:0] MFR_CODE = 16'h00B0,
    parameter logic [15:0] DEV_CODE = 16'h0011
) (
    input  rd_mode_e         mode,
    input  logic [OFS_W-1:0] id_addr,
    input  logic [DW-1:0]    array_data,
    input  logic [DW-1:0]    query_data,
    input  logic [1:0]       lock_cfg,
    input  logic [7:0]       sr,
    output logic [DW-1:0]    rd_data
);

    localparam int LANES = DW / 8;

    logic [DW-1:0] sr_word;
    logic [DW-1:0] id_word;

    // Status byte replicated across byte lanes
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign sr_word[i*8 +: 8] = sr;
    end

    // Identifier-space decode
    always_comb begin
        if (id_addr == OFS_W'(0))                  id_word = MFR_CODE;
        else if (id_addr == OFS_W'(1))             id_word = DEV_CODE;
        else if (id_addr[BLK_W-1:0] == BLK_W'(2))  id_word = {{(DW-2){1'b0}}, lock_cfg};
        else                                       id_word = '0;
    end

    // Mode multiplexer
    always_comb begin
        case (mode)
            RD_STATUS: rd_data = sr_word;
            RD_IDENT:  rd_data = id_word;
            RD_QUERY:  rd_data = query_data;
            default:   rd_data = array_data;
        endcase
    end

endmodule

// File: rtl/flash_cmd_ui.sv
// Top of the flash command interface: decoder, status register and read
// multiplexer. Assumes one host write per wr_en cycle and an eng_done pulse
// only while an engine is running and not in a host-write cycle.
module flash_cmd_ui
    import fcu_pkg::*;
#(
    parameter int AW    = 23,
    parameter int DW    = 16,
    parameter int OFS_W = 16,
    parameter int BLK_W = 15,
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [OFS_W-1:0] id_addr,
    input  logic [DW-1:0]    array_data,
    input  logic [DW-1:0]    query_data,
    input  logic [1:0]       lock_cfg,
    output logic [DW-1:0]    rd_data,
    output logic             go_blk_erase,
    output logic             go_chip_erase,
    output logic             go_word_prog,
    output logic             go_otp_prog,
    output logic             go_lock_set,
    output logic             go_lock_clear,
    output logic             go_lock_down,
    output logic             go_suspend,
    output logic             go_resume,
    output logic [AW-1:0]    op_addr,
    output logic [DW-1:0]    op_data,
    input  logic             eng_done,
    input  logic [NFLAG-1:0] eng_flags
);

    rd_mode_e       mode;
    sr_ev_t         ev;
    logic [NGO-1:0] go;
    logic [7:0]     sr;

    fcu_decoder #(.AW(AW), .DW(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sr_ready(sr[7]), .sr_susp_e(sr[6]),
        .sr_susp_p(sr[2]), .eng_done(eng_done), .rd_mode(mode), .ev(ev),
        .go(go), .op_addr(op_addr), .op_data(op_data)
    );

    fcu_status #(.NFLAG(NFLAG)) u_sr (
        .clk(clk), .rst_n(rst_n), .ev(ev), .eng_done(eng_done),
        .eng_flags(eng_flags), .sr(sr)
    );

    fcu_rdmux #(.DW(DW), .OFS_W(OFS_W), .BLK_W(BLK_W)) u_mux (
        .mode(mode), .id_addr(id_addr), .array_data(array_data),
        .query_data(query_data), .lock_cfg(lock_cfg), .sr(sr),
        .rd_data(rd_data)
    );

    assign go_blk_erase  = go[G_BERASE];
    assign go_chip_erase = go[G_CERASE];
    assign go_word_prog  = go[G_PROG];
    assign go_otp_prog   = go[G_OTP];
    assign go_lock_set   = go[G_LKSET];
    assign go_lock_clear = go[G_LKCLR];
    assign go_lock_down  = go[G_LKDOWN];
    assign go_suspend    = go[G_SUSP];
    assign go_resume     = go[G_RESUME];

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (go_blk_erase || go_chip_erase || go_word_prog || go_otp_prog) |-> !sr[7]); // R4
    AST_LOCK_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (go_lock_set || go_lock_clear || go_lock_down) |-> sr[7]); // R5
    AST_SUSPEND_READY: assert property (@(posedge clk) disable iff (!rst_n)
        go_suspend |-> (sr[7] && (sr[6] || sr[2]))); // R10
    AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        go_resume |-> !sr[7]); // R11
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !wr_en) |=> sr[7]); // R7

endmodule

// File: tb/sim_flash_cmd_ui.sv
module sim_flash_cmd_ui;

    localparam int AW = 23;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] id_addr = '0;
    logic [15:0] array_data = 16'hA5C3;
    logic [15:0] query_data = 16'h5171;
    logic [1:0]  lock_cfg = 2'b00;
    logic [15:0] rd_data;
    logic go_be, go_ce, go_wp, go_otp, go_ls, go_lc, go_ld, go_su, go_re;
    logic [AW-1:0] op_addr;
    logic [15:0] op_data;
    logic        eng_done = 1'b0;
    logic [3:0]  eng_flags = 4'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_ui u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .id_addr(id_addr), .array_data(array_data),
        .query_data(query_data), .lock_cfg(lock_cfg), .rd_data(rd_data),
        .go_blk_erase(go_be), .go_chip_erase(go_ce), .go_word_prog(go_wp),
        .go_otp_prog(go_otp), .go_lock_set(go_ls), .go_lock_clear(go_lc),
        .go_lock_down(go_ld), .go_suspend(go_su), .go_resume(go_re),
        .op_addr(op_addr), .op_data(op_data), .eng_done(eng_done),
        .eng_flags(eng_flags)
    );

    // Strobe order in this vector: resume,suspend,lkdown,lkclr,lkset,otp,prog,cerase,berase
    wire [8:0] go_all = {go_re, go_su, go_ld, go_lc, go_ls, go_otp, go_wp, go_ce, go_be};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d, input logic [AW-1:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_addr = a;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic done(input logic [3:0] f);
        @(negedge clk);
        eng_done = 1'b1; eng_flags = f;
        @(negedge clk);
        eng_done = 1'b0; eng_flags = 4'b0;
    endtask

    task automatic idle1();
        @(negedge clk);
    endtask

    function automatic logic [15:0] id_exp(input logic [15:0] a, input logic [1:0] lk);
        if (a == 16'h0000) return 16'h00B0;
        else if (a == 16'h0001) return 16'h0011;
        else if (a[14:0] == 15'd2) return {14'd0, lk};
        else return 16'h0000;
    endfunction

    function automatic bit known_first(input logic [7:0] c);
        return (c == 8'hFF || c == 8'h70 || c == 8'h50 || c == 8'h90 || c == 8'h98 ||
                c == 8'h20 || c == 8'h30 || c == 8'h40 || c == 8'h10 || c == 8'h60 ||
                c == 8'hC0);
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 array after reset", rd_data, array_data);
        chk("R1 no strobe", go_all, 0);
        wr(16'h0070, 0);
        chk("R1 status after reset", rd_data, 16'h8080);

        // R2 mode selection
        wr(16'h0098, 0);
        chk("R2 query", rd_data, query_data);
        wr(16'h00FF, 0);
        chk("R2 array", rd_data, array_data);
        array_data = 16'h3C00; #1;
        chk("R2 array follows", rd_data, 16'h3C00);
        wr(16'h0070, 0);
        chk("R2 status mirror", rd_data, 16'h8080);

        // R3 identifier sweep
        wr(16'h0090, 0);
        for (int b = 0; b < 2; b++) begin
            for (int o = 0; o < 6; o++) begin
                id_addr = 16'((b << 15) + o);
                lock_cfg = 2'(o + b);
                #1;
                chk("R3 ident", rd_data, id_exp(id_addr, lock_cfg));
            end
        end
        id_addr = 16'h7002; #1;
        chk("R3 ident non-base", rd_data, 16'h0000);

        // R9 sweep of first-cycle bytes from array mode
        wr(16'h00FF, 0);
        for (int c = 0; c < 256; c++) begin
            if (!known_first(8'(c))) begin
                wr(16'(c), 23'h12345);
                chk("R9 mode kept", rd_data, array_data);
                chk("R9 no strobe", go_all, 0);
            end
        end
        wr(16'h0070, 0);
        chk("R9 status unchanged", rd_data, 16'h8080);

        // R4 block erase
        wr(16'h0020, 23'h0A8000);
        chk("R4 setup no strobe", go_all, 0);
        wr(16'h00D0, 23'h0A8010);
        chk("R4 berase strobe", go_all, 9'b0_0000_0001);
        chk("R4 berase addr", op_addr, 23'h0A8010);
        chk("R4 busy", rd_data, 16'h0000);
        idle1();
        chk("R4 strobe one cycle", go_all, 0);
        done(4'b0000);
        chk("R7 ready after done", rd_data, 16'h8080);

        // R4 chip erase
        wr(16'h0030, 0);
        wr(16'h00D0, 23'h000777);
        chk("R4 cerase strobe", go_all, 9'b0_0000_0010);
        done(4'b0000);

        // R4 word program with 40h, R7 program error
        wr(16'h00FF, 0);
        wr(16'h0040, 23'h001000);
        chk("R4 setup selects status", rd_data, 16'h8080);
        wr(16'h1234, 23'h001004);
        chk("R4 prog strobe", go_all, 9'b0_0000_0100);
        chk("R4 prog data", op_data, 16'h1234);
        chk("R4 prog addr", op_addr, 23'h001004);
        done(4'b0100);
        chk("R7 program error", rd_data, 16'h9090);
        wr(16'h0050, 0);
        chk("R8 clear", rd_data, 16'h8080);

        // R4 program with 10h, R7 multiple flags, R8 stickiness
        wr(16'h0010, 23'h000002);
        wr(16'hBEEF, 23'h000002);
        chk("R4 prog alt strobe", go_all, 9'b0_0000_0100);
        done(4'b1011);
        chk("R7 flags 5,3,1", rd_data, 16'hAAAA);
        wr(16'h00FF, 0);
        wr(16'h0070, 0);
        chk("R8 sticky", rd_data, 16'hAAAA);
        wr(16'h0050, 0);
        chk("R8 clear keeps ready", rd_data, 16'h8080);

        // R6 bad second cycles
        wr(16'h0020, 0);
        wr(16'h0055, 0);
        chk("R6 erase bad no strobe", go_all, 0);
        chk("R6 erase bad bits", rd_data, 16'hB0B0);
        wr(16'h0050, 0);
        wr(16'h0030, 0);
        wr(16'h00FF, 0);
        chk("R6 chip bad bits", rd_data, 16'hB0B0);
        wr(16'h0050, 0);
        wr(16'h0060, 0);
        wr(16'h0077, 0);
        chk("R6 lock bad no strobe", go_all, 0);
        chk("R6 lock bad bits", rd_data, 16'hB0B0);
        wr(16'h0050, 0);

        // R5 lock commands
        wr(16'h0060, 23'h010000);
        wr(16'h0001, 23'h010000);
        chk("R5 lock set", go_all, 9'b0_0001_0000);
        chk("R5 ready", rd_data, 16'h8080);
        wr(16'h0060, 23'h010000);
        wr(16'h00D0, 23'h010000);
        chk("R5 lock clear", go_all, 9'b0_0010_0000);
        wr(16'h0060, 23'h018000);
        wr(16'h002F, 23'h018000);
        chk("R5 lock down", go_all, 9'b0_0100_0000);
        chk("R5 lock addr", op_addr, 23'h018000);

        // R10/R11/R12 suspend, nested program, resume order
        wr(16'h0020, 23'h020000);
        wr(16'h00D0, 23'h020000);
        wr(16'h00B0, 0);
        chk("R10 suspend erase strobe", go_all, 9'b0_1000_0000);
        chk("R10 erase suspended", rd_data, 16'hC0C0);
        wr(16'h0040, 23'h030000);
        wr(16'h5AA5, 23'h030000);
        chk("R12 prog during erase suspend", go_all, 9'b0_0000_0100);
        chk("R12 busy with erase suspended", rd_data, 16'h4040);
        wr(16'h00B0, 0);
        chk("R10 suspend prog strobe", go_all, 9'b0_1000_0000);
        chk("R10 both suspended", rd_data, 16'hC4C4);
        wr(16'h00C0, 0);
        chk("R12 otp refused", go_all, 0);
        wr(16'h0020, 0);
        chk("R12 erase refused", go_all, 0);
        chk("R12 status kept", rd_data, 16'hC4C4);
        wr(16'h00D0, 0);
        chk("R11 resume strobe", go_all, 9'b1_0000_0000);
        chk("R11 program resumed first", rd_data, 16'h4040);
        done(4'b0000);
        chk("R11 prog done", rd_data, 16'hC0C0);
        wr(16'h00C0, 0);
        wr(16'h1234, 0);
        chk("R12 otp refused erase susp", rd_data, 16'hC0C0);
        wr(16'h00D0, 0);
        chk("R11 resume erase strobe", go_all, 9'b1_0000_0000);
        chk("R11 erase resumed", rd_data, 16'h0000);
        done(4'b0000);
        chk("R11 erase done", rd_data, 16'h8080);

        // R10 chip erase and OTP not suspendable; R12 busy refusals
        wr(16'h0030, 0);
        wr(16'h00D0, 0);
        wr(16'h00B0, 0);
        chk("R10 chip erase no suspend", go_all, 0);
        chk("R10 still busy", rd_data, 16'h0000);
        wr(16'h0040, 0);
        wr(16'h0055, 0);
        chk("R12 busy setup ignored", go_all, 0);
        chk("R12 busy status", rd_data, 16'h0000);
        done(4'b0000);
        wr(16'h00C0, 23'h000081);
        wr(16'h00CA, 23'h000081);
        chk("R4 otp strobe", go_all, 9'b0_0000_1000);
        chk("R4 otp data", op_data, 16'h00CA);
        wr(16'h00B0, 0);
        chk("R10 otp no suspend", go_all, 0);
        chk("R10 otp still busy", rd_data, 16'h0000);
        done(4'b0000);
        chk("R7 final ready", rd_data, 16'h8080);

        // R1 reset again from a dirty state
        wr(16'h0020, 0);
        wr(16'h0011, 0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 array after re-reset", rd_data, array_data);
        wr(16'h0070, 0);
        chk("R1 errors cleared by reset", rd_data, 16'h8080);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule